// File: doc/BRIEF.md
# Compare-Clear Event Counter

This block counts transitions on an external event line instead of ticks of its own clock. The line is first brought into the system clock domain by a flop chain. An edge-select field then decides which transitions count: rising, falling, both, or none. Each accepted transition advances a 16-bit count. A period register sets where the count turns over. When the count already equals that register, the next accepted transition returns the count to zero instead of stepping it. The compare-match interrupt fires on that same transition.

The turnover is deferred by one event. A period value of all ones therefore gives a full 65536-event cycle, and that wrap is a period match, not an overflow. The overflow flag is set only when the count runs off the top of its range without matching the period. That happens when the period is lowered below a count already reached. A second compare register gives its own pulse when the count steps onto its value. A small write port sets up the control bits and both compare values. This port rejects zero compare values. The timer output pins stay inactive in this mode.

Top module: `evt_cmp_counter`

## Requirements
- R1: The event input passes through a two-flop synchronizer and a history flop. Control bits [2:1] select which edges count: 00 none, 01 rising, 10 falling, 11 both. A change on the event input made between clock edges shows in `count_q` after the third following rising clock edge. Between accepted edges, the count holds its value.
- R2: When an accepted edge arrives while the count equals the period register, the count goes to 0 instead of incrementing. `match_irq` is high for exactly that one cycle, the cycle in which the count first reads 0.
- R3: With the period register at 16'hFFFF, the count climbs to 16'hFFFF and returns to 0 on the next accepted edge. One `match_irq` pulse occurs per 65536 edges, and `ovf_flag` stays low.
- R4: An accepted edge at count 16'hFFFF that does not match the period wraps the count to 0 and sets the sticky `ovf_flag`. A write to address 0 with data bit 3 set clears the flag. A set in the same cycle wins over the clear.
- R5: Address 1 is the period register and address 2 is the second compare register. Writing 0 to either one leaves it unchanged and raises `wr_err` for one cycle. A nonzero write takes effect on the next cycle.
- R6: Control bit 0 is the enable. While it is 0, the count is held at 0 and no interrupt fires.
- R7: `cmp1_irq` pulses for one cycle when the count steps onto the value of the second compare register.
- R8: `tmr_out` is always 0.
- R9: After reset, the count is 0, both compare registers are 16'hFFFF, the enable is 0, edge select is 00, and all pulses and flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 period, 2 second compare, 3 unused |
| wr_data | input | 16 | Write data |
| evt_in | input | 1 | Asynchronous external event line |
| count_q | output | 16 | Current event count |
| match_irq | output | 1 | Period match pulse, issued as the count clears |
| cmp1_irq | output | 1 | Second compare match pulse |
| ovf_flag | output | 1 | Sticky overflow status |
| wr_err | output | 1 | Pulse for a rejected zero compare write |
| period_q | output | 16 | Period register value |
| cmp1_q | output | 16 | Second compare register value |
| tmr_out | output | 2 | Timer output pins, held inactive |

## Verification
The properties assume that the period register never holds zero. The write port guarantees this, and the bench also attempts zero writes to confirm that guarantee. They also assume that the event line changes at most once per clock. The bench changes it only on falling clock edges, at most once per cycle, so the both-edges mode can be driven at one event per clock. The properties also assume that writes are single-cycle strobes with a stable address. The bench drives each write for exactly one cycle between falling edges.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   localparam int unsigned ADDR_W       = 2;
   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned CTRL_SEL_LSB = 1;
   localparam int unsigned CTRL_OVC_BIT = 3;
   localparam int unsigned CTRL_MIN_W   = 4;

   localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
   localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
   localparam logic [ADDR_W-1:0] ADDR_CMP1   = 2'd2;

endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync
   import evt_cnt_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      evt_in,
   input  edge_sel_e sel,
   output logic      evt_pulse
);

   localparam int unsigned TOP = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("evt_edge_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] chain;
   logic                   hist;
   logic                   rise, fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         hist  <= 1'b0;
      end else begin
         chain <= {chain[SYNC_STAGES-2:0], evt_in};
         hist  <= chain[TOP];
      end
   end

   assign rise = chain[TOP] & ~hist;
   assign fall = ~chain[TOP] & hist;

   always_comb begin
      unique case (sel)
         EDGE_NONE: evt_pulse = 1'b0;
         EDGE_RISE: evt_pulse = rise;
         EDGE_FALL: evt_pulse = fall;
         EDGE_BOTH: evt_pulse = rise | fall;
         default:   evt_pulse = 1'b0;
      endcase
   end

   AST_NO_EDGE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == EDGE_NONE) |-> !evt_pulse); // R1

   AST_PULSE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |-> (chain[TOP] != hist)); // R1

endmodule

// File: rtl/evt_reg_if.sv
module evt_reg_if
   import evt_cnt_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              ovf_set,
   output logic              en,
   output edge_sel_e         sel,
   output logic [CNT_W-1:0]  period,
   output logic [CNT_W-1:0]  cmp1,
   output logic              ovf_flag,
   output logic              wr_err
);

   localparam logic [CNT_W-1:0] CMP_RESET = '1;

   generate
      if (CNT_W < CTRL_MIN_W) begin : g_bad_width
         $error("evt_reg_if: CNT_W too narrow for the control bits");
      end
   endgenerate

   logic wr_ctrl, wr_per, wr_c1, data_zero, ovf_clr;

   assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
   assign wr_per    = wr_en && (wr_addr == ADDR_PERIOD);
   assign wr_c1     = wr_en && (wr_addr == ADDR_CMP1);
   assign data_zero = (wr_data == '0);
   assign ovf_clr   = wr_ctrl && wr_data[CTRL_OVC_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         sel    <= EDGE_NONE;
         period <= CMP_RESET;
         cmp1   <= CMP_RESET;
         wr_err <= 1'b0;
      end else begin
         wr_err <= (wr_per || wr_c1) && data_zero;
         if (wr_ctrl) begin
            en  <= wr_data[CTRL_EN_BIT];
            sel <= edge_sel_e'(wr_data[CTRL_SEL_LSB +: 2]);
         end
         if (wr_per && !data_zero) period <= wr_data;
         if (wr_c1 && !data_zero)  cmp1   <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_flag <= 1'b0;
      else if (ovf_set) ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
   end

   AST_ZERO_PERIOD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_per && data_zero) |=> ($stable(period) && wr_err)); // R5

   AST_ZERO_CMP1_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c1 && data_zero) |=> ($stable(cmp1) && wr_err)); // R5

   AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (period != '0) && (cmp1 != '0)); // R5

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             evt_pulse,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] cmp1,
   output logic [CNT_W-1:0] count,
   output logic             match_irq,
   output logic             cmp1_irq,
   output logic             ovf_set
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             step, at_period, at_max;
   logic [CNT_W-1:0] nxt;

   assign step      = en && evt_pulse;
   assign at_period = (count == period);
   assign at_max    = (count == CNT_MAX);
   assign nxt       = count + 1'b1;
   assign ovf_set   = step && at_max && !at_period;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count     <= '0;
         match_irq <= 1'b0;
         cmp1_irq  <= 1'b0;
      end else begin
         match_irq <= 1'b0;
         cmp1_irq  <= 1'b0;
         if (!en) begin
            count <= '0;
         end else if (evt_pulse) begin
            if (at_period) begin
               count     <= '0;
               match_irq <= 1'b1;
            end else begin
               count    <= nxt;
               cmp1_irq <= (nxt == cmp1);
            end
         end
      end
   end

   AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_period) |=> ((count == '0) && match_irq)); // R2

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      match_irq |=> !match_irq); // R2

   AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ((count == '0) && !match_irq)); // R6

   AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !evt_pulse) |=> (count == $past(count))); // R1

   AST_CMP1_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      cmp1_irq |-> (count == $past(cmp1))); // R7

endmodule

// File: rtl/evt_cmp_counter.sv
module evt_cmp_counter
   import evt_cnt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TOUT_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              evt_in,
   output logic [CNT_W-1:0]  count_q,
   output logic              match_irq,
   output logic              cmp1_irq,
   output logic              ovf_flag,
   output logic              wr_err,
   output logic [CNT_W-1:0]  period_q,
   output logic [CNT_W-1:0]  cmp1_q,
   output logic [TOUT_W-1:0] tmr_out
);

   generate
      if (TOUT_W < 1) begin : g_bad_tout
         $error("evt_cmp_counter: TOUT_W must be at least 1");
      end
   endgenerate

   logic      en, evt_pulse, ovf_set;
   edge_sel_e sel;

   evt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_in    (evt_in),
      .sel       (sel),
      .evt_pulse (evt_pulse)
   );

   evt_reg_if #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .ovf_set  (ovf_set),
      .en       (en),
      .sel      (sel),
      .period   (period_q),
      .cmp1     (cmp1_q),
      .ovf_flag (ovf_flag),
      .wr_err   (wr_err)
   );

   evt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .evt_pulse (evt_pulse),
      .period    (period_q),
      .cmp1      (cmp1_q),
      .count     (count_q),
      .match_irq (match_irq),
      .cmp1_irq  (cmp1_irq),
      .ovf_set   (ovf_set)
   );

   assign tmr_out = '0;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      match_irq |-> !$rose(ovf_flag)); // R3

   AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> (ovf_flag && (count_q == '0))); // R4

endmodule

// File: tb/tb_evt_cmp_counter.sv
`timescale 1ns/1ps
module tb_evt_cmp_counter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        evt_in = 1'b0;
   logic [15:0] count_q, period_q, cmp1_q;
   logic        match_irq, cmp1_irq, ovf_flag, wr_err;
   logic [1:0]  tmr_out;

   always #4 clk = ~clk;

   evt_cmp_counter dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .evt_in(evt_in), .count_q(count_q),
      .match_irq(match_irq), .cmp1_irq(cmp1_irq), .ovf_flag(ovf_flag),
      .wr_err(wr_err), .period_q(period_q), .cmp1_q(cmp1_q), .tmr_out(tmr_out)
   );

   int nchk = 0, nfail = 0, irq_seen = 0;
   bit done = 0;

   // behavioural reference
   bit q[$];
   bit m_prev, m_en, m_ovf, m_irq, m_c1, m_err;
   int m_cnt, m_per, m_cmp1, m_sel;

   task automatic chk(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         q = {1'b0, 1'b0};
         m_prev = 0; m_en = 0; m_ovf = 0; m_irq = 0; m_c1 = 0; m_err = 0;
         m_cnt = 0; m_per = 65535; m_cmp1 = 65535; m_sel = 0;
      end else begin
         bit s, e, oset;
         s = q[0];
         case (m_sel)
            1: e = s && !m_prev;
            2: e = !s && m_prev;
            3: e = s != m_prev;
            default: e = 0;
         endcase
         m_irq = 0; m_c1 = 0; oset = 0;
         if (!m_en) m_cnt = 0;
         else if (e) begin
            if (m_cnt == m_per) begin m_cnt = 0; m_irq = 1; end
            else begin
               if (m_cnt == 65535) oset = 1;
               m_cnt = (m_cnt + 1) % 65536;
               if (m_cnt == m_cmp1) m_c1 = 1;
            end
         end
         m_err = 0;
         if (wr_en) begin
            case (wr_addr)
               2'd0: begin m_en = wr_data[0]; m_sel = int'(wr_data[2:1]); end
               2'd1: if (wr_data == 0) m_err = 1; else m_per = int'(wr_data);
               2'd2: if (wr_data == 0) m_err = 1; else m_cmp1 = int'(wr_data);
               default: ;
            endcase
         end
         if (oset) m_ovf = 1;
         else if (wr_en && wr_addr == 2'd0 && wr_data[3]) m_ovf = 0;
         m_prev = s;
         void'(q.pop_front());
         q.push_back(evt_in);
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 count", int'(count_q), m_cnt);
         chk("R2 match_irq", int'(match_irq), int'(m_irq));
         chk("R7 cmp1_irq", int'(cmp1_irq), int'(m_c1));
         chk("R4 ovf_flag", int'(ovf_flag), int'(m_ovf));
         chk("R5 wr_err", int'(wr_err), int'(m_err));
         chk("R5 period", int'(period_q), m_per);
         chk("R5 cmp1", int'(cmp1_q), m_cmp1);
         chk("R8 tmr_out", int'(tmr_out), 0);
         if (match_irq) irq_seen++;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic pulses(input int n, input int hold);
      for (int i = 0; i < n; i++) begin
         repeat (hold) @(negedge clk);
         evt_in = 1;
         repeat (hold) @(negedge clk);
         evt_in = 0;
      end
      repeat (5) @(negedge clk);
   endtask

   task automatic toggles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         evt_in = ~evt_in;
      end
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 count", int'(count_q), 0);
      chk("R9 period", int'(period_q), 65535);
      chk("R9 cmp1", int'(cmp1_q), 65535);
      chk("R9 flags", int'({match_irq, cmp1_irq, ovf_flag, wr_err}), 0);
      @(negedge clk); rst_n = 1;
      // R9 edge select 00 and enable 0 after reset
      pulses(3, 2);
      chk("R9 idle", int'(count_q), 0);
      // R2 period 5, rising edges
      wr(2'd1, 16'd5);
      wr(2'd0, 16'h0003);
      base = irq_seen;
      pulses(6, 3);
      chk("R2 clear after period", int'(count_q), 0);
      chk("R2 one irq", irq_seen - base, 1);
      // R7 second compare
      wr(2'd2, 16'd3);
      pulses(4, 2);
      chk("R7 count", int'(count_q), 4);
      // R1 falling, both, none
      wr(2'd0, 16'h0005);
      pulses(1, 2);
      wr(2'd0, 16'h0007);
      pulses(2, 2);
      wr(2'd0, 16'h0001);
      pulses(3, 2);
      chk("R1 none ignored", int'(count_q), 3);
      // R5 zero writes
      wr(2'd1, 16'd0);
      wr(2'd2, 16'd0);
      chk("R5 period kept", int'(period_q), 5);
      chk("R5 cmp1 kept", int'(cmp1_q), 3);
      // R6 disable holds zero
      wr(2'd0, 16'h0006);
      pulses(3, 2);
      chk("R6 held", int'(count_q), 0);
      // R3 full cycle at FFFF, one event per clock
      wr(2'd1, 16'hFFFF);
      wr(2'd0, 16'h0007);
      base = irq_seen;
      toggles(65536);
      chk("R3 wrapped count", int'(count_q), 0);
      chk("R3 single irq", irq_seen - base, 1);
      chk("R3 no overflow", int'(ovf_flag), 0);
      // R4 lower period below reached count
      toggles(100);
      wr(2'd1, 16'd10);
      toggles(65536 - 100);
      chk("R4 overflow set", int'(ovf_flag), 1);
      wr(2'd0, 16'h000F);
      chk("R4 overflow cleared", int'(ovf_flag), 0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule